// File: doc/BRIEF.md
# Serial Audio Transmitter with Underrun Fill

This block turns parallel two-channel audio samples into a serial bit stream with a word-select line. It runs on the system clock and advances one serial bit per pulse of a bit-clock strobe supplied from outside, so the bit rate is set entirely by the strobe generator. The framing is either classic I2S, where data trails the word-select edge by one bit, or left-justified, where they coincide.

Samples arrive through a single-entry holding register with a valid/ready handshake. The sample length is picked from a 3-bit code, and two packed codes carry both channels in one word. A mono switch repeats the left sample in the right slot. When a slot starts and no sample is waiting, the block sends a zero or repeats the channel's last real sample, and it raises a sticky per-channel underrun flag. The configuration is captured at each frame start, so changes made mid-frame take effect on the next frame.

Top module: `i2s_tx`

## Requirements
- R1: A pulse on `en_cmd_i` enables the transmitter and a pulse on `dis_cmd_i` disables it, with disable winning when both pulse together; `tx_en_o` shows the state one cycle later. While disabled, `tx_ready_o`, `ws_o` and `sd_o` stay low.
- R2: `tx_ready_o` is high exactly when the transmitter is enabled and the holding register is empty. An accepted word drops it on the next cycle, and the word is consumed at the slot start that needs it. Disabling empties the holding register.
- R3: Each frame is a left slot followed by a right slot of equal width. `ws_o` is low for the left slot and high for the right slot. `ws_o` and `sd_o` change only on a `bit_tick_i` strobe or when the block is disabled.
- R4: With `fmt_lj_i` = 1 (left-justified), the slot MSB is driven in the same bit period in which `ws_o` changes.
- R5: With `fmt_lj_i` = 0 (I2S), every data bit appears one bit period after its left-justified position. The first bit period after enable carries 0.
- R6: `dlen_i` selects the sample length: 0 = 32, 1 = 24, 2 = 20, 3 = 18, 4 = 16, 5 = packed 16, 6 = 8, 7 = packed 8 bits. A sample is taken from the low bits of the word and sent MSB first. Slot bits below the sample are 0.
- R7: The slot is 32 bits wide. It is 24 bits wide only when `slot24_i` = 1 and `dlen_i` is 1, 2 or 3. For any other length, `slot24_i` has no effect.
- R8: In packed modes one word feeds a whole frame. Packed 16 sends bits [15:0] left and [31:16] right. Packed 8 sends bits [7:0] left and [15:8] right.
- R9: With `mono_i` = 1 and a non-packed length, one word per frame is taken, and the left sample is sent in both slots.
- R10: If no word is waiting when a slot needs one and `fill_prev_i` = 0, that slot carries all zeros.
- R11: If no word is waiting when a slot needs one and `fill_prev_i` = 1, the slot repeats the last real sample sent on that channel.
- R12: An underrun sets `ur_ch_o[0]` for the left channel and `ur_ch_o[1]` for the right channel. A packed-mode underrun at frame start sets both bits. The flags stay set until a `ur_clr_i` pulse, and `ur_o` is their OR.
- R13: The format, length, slot width, mono and fill settings are captured at the first bit of each frame. A change made during a frame leaves that frame unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_cmd_i | input | 1 | Enable command pulse |
| dis_cmd_i | input | 1 | Disable command pulse |
| fmt_lj_i | input | 1 | 1 = left-justified, 0 = I2S |
| dlen_i | input | 3 | Sample length code |
| slot24_i | input | 1 | 24-bit slot for 18/20/24-bit lengths |
| mono_i | input | 1 | Duplicate left sample into right slot |
| fill_prev_i | input | 1 | Underrun fill: 1 = previous sample, 0 = zero |
| ur_clr_i | input | 1 | Clear underrun flags |
| bit_tick_i | input | 1 | One-cycle strobe per serial bit |
| tx_data_i | input | 32 | Sample word |
| tx_valid_i | input | 1 | Sample word valid |
| tx_ready_o | output | 1 | Holding register can accept a word |
| tx_en_o | output | 1 | Transmitter enabled |
| ws_o | output | 1 | Word select |
| sd_o | output | 1 | Serial data |
| ur_o | output | 1 | Any underrun flag set |
| ur_ch_o | output | 2 | Per-channel underrun flags |

## Verification
The bench decodes the captured serial stream and checks it against the I2S one-bit delay. A design that aligns data with word select would shift every I2S slot by one bit and corrupt the MSB. It checks the 24-bit slot case and its mirror, where the slot option is given for a 16-bit length. A wrong slot decode there would move the word-select edge away from bit 32. Packed and mono frames are checked to use one word per frame, since a design that pulls a second word would underrun or mix up channels. The underrun tests confirm zero fill and previous-sample fill per channel, with the right flag bits set, and that a length change made mid-frame waits for the next frame.

// File: rtl/i2s_tx_pkg.sv
`timescale 1ns/1ps
package i2s_tx_pkg;
  localparam int unsigned SMP_W  = 32;
  localparam int unsigned NCH    = 2;
  localparam int unsigned SLEN_W = $clog2(SMP_W) + 1;

  typedef enum logic [2:0] {
    DL_32  = 3'd0,
    DL_24  = 3'd1,
    DL_20  = 3'd2,
    DL_18  = 3'd3,
    DL_16  = 3'd4,
    DL_16P = 3'd5,
    DL_8   = 3'd6,
    DL_8P  = 3'd7
  } dlen_e;

  typedef struct packed {
    logic  lj;
    dlen_e dlen;
    logic  slot24;
    logic  mono;
    logic  fill_prev;
  } cfg_t;

  function automatic logic [SLEN_W-1:0] dlen_bits(dlen_e d);
    case (d)
      DL_32:         return SLEN_W'(32);
      DL_24:         return SLEN_W'(24);
      DL_20:         return SLEN_W'(20);
      DL_18:         return SLEN_W'(18);
      DL_16, DL_16P: return SLEN_W'(16);
      default:       return SLEN_W'(8);
    endcase
  endfunction

  function automatic logic is_packed(dlen_e d);
    return (d == DL_16P) || (d == DL_8P);
  endfunction

  function automatic logic [SLEN_W-1:0] slot_bits(cfg_t c);
    if (c.slot24 && (c.dlen inside {DL_24, DL_20, DL_18})) return SLEN_W'(24);
    return SLEN_W'(32);
  endfunction
endpackage

// File: rtl/i2s_tx_hold.sv
`timescale 1ns/1ps
module i2s_tx_hold #(
  parameter int unsigned W = i2s_tx_pkg::SMP_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         valid_i,
  input  logic [W-1:0] data_i,
  input  logic         take_i,
  output logic         ready_o,
  output logic         full_o,
  output logic [W-1:0] data_o
);
  logic         full_q;
  logic [W-1:0] data_q;

  assign ready_o = en_i && !full_q;
  assign full_o  = full_q;
  assign data_o  = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (!en_i) begin
      full_q <= 1'b0;
    end else if (take_i) begin
      full_q <= 1'b0;
    end else if (valid_i && ready_o) begin
      full_q <= 1'b1;
      data_q <= data_i;
    end
  end
endmodule

// File: rtl/i2s_tx_src.sv
`timescale 1ns/1ps
module i2s_tx_src
  import i2s_tx_pkg::*;
#(
  parameter int unsigned W = SMP_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           ch_i,
  input  cfg_t           cfg_i,
  input  logic           hold_full_i,
  input  logic [W-1:0]   hold_data_i,
  output logic           take_o,
  output logic [W-1:0]   word_o,
  output logic [NCH-1:0] ur_o
);
  logic [SLEN_W-1:0] dbits;
  logic [W-1:0]      msk, raw_l, raw_r, smp, fill_l, fill_r;
  logic [W-1:0]      pend_d, pend_q;
  logic              pk, pair, pend_we;
  logic [NCH-1:0]    upd;
  logic [NCH-1:0][W-1:0] upd_val, prev_q;

  always_comb begin
    dbits  = dlen_bits(cfg_i.dlen);
    msk    = ~({W{1'b1}} << dbits);
    pk     = is_packed(cfg_i.dlen);
    pair   = pk || cfg_i.mono;
    raw_l  = hold_data_i;
    raw_r  = hold_data_i;
    if (cfg_i.dlen == DL_16P) begin
      raw_l = W'(hold_data_i[15:0]);
      raw_r = W'(hold_data_i[31:16]);
    end else if (cfg_i.dlen == DL_8P) begin
      raw_l = W'(hold_data_i[7:0]);
      raw_r = W'(hold_data_i[15:8]);
    end
    fill_l = cfg_i.fill_prev ? (prev_q[0] & msk) : '0;
    fill_r = cfg_i.fill_prev ? (prev_q[1] & msk) : '0;
    take_o     = 1'b0;
    ur_o       = '0;
    upd        = '0;
    upd_val[0] = raw_l & msk;
    upd_val[1] = raw_r & msk;
    smp        = '0;
    pend_we    = 1'b0;
    pend_d     = pend_q;
    if (load_i && !ch_i) begin
      pend_we = pair;
      if (hold_full_i) begin
        take_o = 1'b1;
        smp    = raw_l & msk;
        upd[0] = 1'b1;
        upd[1] = pk;
        pend_d = pk ? (raw_r & msk) : (raw_l & msk);
      end else begin
        ur_o[0] = 1'b1;
        ur_o[1] = pk;
        smp     = fill_l;
        pend_d  = pk ? fill_r : fill_l;
      end
    end else if (load_i) begin
      if (pair) begin
        smp = pend_q & msk;
      end else if (hold_full_i) begin
        take_o     = 1'b1;
        smp        = raw_l & msk;
        upd[1]     = 1'b1;
        upd_val[1] = raw_l & msk;
      end else begin
        ur_o[1] = 1'b1;
        smp     = fill_r;
      end
    end
  end

  // MSB-align the sample inside a full-width word
  assign word_o = smp << (SLEN_W'(W) - dbits);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (upd[c]) prev_q[c] <= upd_val[c];
      end
      if (pend_we) pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/i2s_tx_ser.sv
`timescale 1ns/1ps
module i2s_tx_ser #(
  parameter  int unsigned W      = i2s_tx_pkg::SMP_W,
  localparam int unsigned SW_W   = $clog2(W) + 1,
  localparam int unsigned POS_W  = $clog2(2 * W)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            tick_i,
  input  logic            lj_i,
  input  logic [SW_W-1:0] sw_i,
  input  logic [W-1:0]    word_i,
  output logic            frame_start_o,
  output logic            load_o,
  output logic            ch_o,
  output logic            ws_o,
  output logic            sd_o
);
  logic [POS_W-1:0] pos_q;
  logic [POS_W:0]   pos_x, sw_x, last_x;
  logic [W-1:0]     sh_q, cur;
  logic             ws_q, lj_bit_q, sd_q, bit_now;

  assign pos_x  = {1'b0, pos_q};
  assign sw_x   = (POS_W+1)'(sw_i);
  assign last_x = (sw_x << 1) - 1'b1;

  assign frame_start_o = run_i && tick_i && (pos_q == '0);
  assign load_o        = run_i && tick_i && ((pos_q == '0) || (pos_x == sw_x));
  assign ch_o          = (pos_q != '0);

  assign cur     = load_o ? word_i : sh_q;
  assign bit_now = cur[W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q    <= '0;
      sh_q     <= '0;
      ws_q     <= 1'b0;
      lj_bit_q <= 1'b0;
      sd_q     <= 1'b0;
    end else if (!run_i) begin
      pos_q    <= '0;
      sh_q     <= '0;
      ws_q     <= 1'b0;
      lj_bit_q <= 1'b0;
      sd_q     <= 1'b0;
    end else if (tick_i) begin
      sh_q     <= cur << 1;
      ws_q     <= (pos_x >= sw_x);
      lj_bit_q <= bit_now;
      // I2S: emit the bit computed one strobe earlier
      sd_q     <= lj_i ? bit_now : lj_bit_q;
      pos_q    <= (pos_x == last_x) ? '0 : pos_q + 1'b1;
    end
  end

  assign ws_o = ws_q;
  assign sd_o = sd_q;
endmodule

// File: rtl/i2s_tx.sv
`timescale 1ns/1ps
module i2s_tx
  import i2s_tx_pkg::*;
#(
  parameter int unsigned W = SMP_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_cmd_i,
  input  logic           dis_cmd_i,
  input  logic           fmt_lj_i,
  input  logic [2:0]     dlen_i,
  input  logic           slot24_i,
  input  logic           mono_i,
  input  logic           fill_prev_i,
  input  logic           ur_clr_i,
  input  logic           bit_tick_i,
  input  logic [W-1:0]   tx_data_i,
  input  logic           tx_valid_i,
  output logic           tx_ready_o,
  output logic           tx_en_o,
  output logic           ws_o,
  output logic           sd_o,
  output logic           ur_o,
  output logic [NCH-1:0] ur_ch_o
);
  logic              en_q;
  cfg_t              cfg_in, cfg_q, cfg_eff;
  logic [SLEN_W-1:0] sw_eff;
  logic              frame_start, load, ch, take, hold_full;
  logic [W-1:0]      hold_data, word;
  logic [NCH-1:0]    ur_pulse;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        en_q <= 1'b0;
    else if (dis_cmd_i) en_q <= 1'b0;
    else if (en_cmd_i)  en_q <= 1'b1;
  end
  assign tx_en_o = en_q;

  always_comb begin
    cfg_in.lj        = fmt_lj_i;
    cfg_in.dlen      = dlen_e'(dlen_i);
    cfg_in.slot24    = slot24_i;
    cfg_in.mono      = mono_i;
    cfg_in.fill_prev = fill_prev_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cfg_q <= '0;
    else if (frame_start) cfg_q <= cfg_in;
  end

  // frame start sees the live settings; the rest of the frame uses the capture
  assign cfg_eff = frame_start ? cfg_in : cfg_q;
  assign sw_eff  = slot_bits(cfg_eff);

  i2s_tx_hold #(.W(W)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_q),
    .valid_i (tx_valid_i),
    .data_i  (tx_data_i),
    .take_i  (take),
    .ready_o (tx_ready_o),
    .full_o  (hold_full),
    .data_o  (hold_data)
  );

  i2s_tx_src #(.W(W)) u_src (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .ch_i        (ch),
    .cfg_i       (cfg_eff),
    .hold_full_i (hold_full),
    .hold_data_i (hold_data),
    .take_o      (take),
    .word_o      (word),
    .ur_o        (ur_pulse)
  );

  i2s_tx_ser #(.W(W)) u_ser (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .run_i         (en_q),
    .tick_i        (bit_tick_i),
    .lj_i          (cfg_eff.lj),
    .sw_i          (sw_eff),
    .word_i        (word),
    .frame_start_o (frame_start),
    .load_o        (load),
    .ch_o          (ch),
    .ws_o          (ws_o),
    .sd_o          (sd_o)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          flag_q <= 1'b0;
      else if (ur_pulse[c]) flag_q <= 1'b1;
      else if (ur_clr_i)    flag_q <= 1'b0;
    end
    assign ur_ch_o[c] = flag_q;
  end

  assign ur_o = |ur_ch_o;
endmodule

// File: rtl/i2s_tx_chk.sv
`timescale 1ns/1ps
module i2s_tx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       dis_cmd_i,
  input logic       ur_clr_i,
  input logic       bit_tick_i,
  input logic       tx_valid_i,
  input logic       tx_ready_o,
  input logic       tx_en_o,
  input logic       ws_o,
  input logic       sd_o,
  input logic [1:0] ur_ch_o
);
  AST_DIS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_en_o && $past(!tx_en_o)) |-> (!ws_o && !sd_o && !tx_ready_o)); // R1

  AST_READY_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |-> tx_en_o); // R2

  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_i && tx_ready_o) |=> !tx_ready_o); // R2

  AST_OUT_HOLDS_BETWEEN_TICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bit_tick_i && !dis_cmd_i && tx_en_o) |=> ($stable(ws_o) && $stable(sd_o))); // R3

  AST_UR_L_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ur_ch_o[0] && !ur_clr_i) |=> ur_ch_o[0]); // R12

  AST_UR_R_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ur_ch_o[1] && !ur_clr_i) |=> ur_ch_o[1]); // R12

  AST_UR_ONLY_RUNNING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ur_ch_o[0]) |-> $past(tx_en_o)); // R10
endmodule

bind i2s_tx i2s_tx_chk u_chk (.*);

// File: tb/i2s_tx_tb_top.sv
`timescale 1ns/1ps
module i2s_tx_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_cmd = 1'b0, dis_cmd = 1'b0, fmt_lj = 1'b1;
  logic [2:0]  dlen = 3'd0;
  logic        slot24 = 1'b0, mono = 1'b0, fill_prev = 1'b0, ur_clr = 1'b0;
  logic        bit_tick = 1'b0, tx_valid = 1'b0;
  logic [31:0] tx_data = '0;
  logic        tx_ready, tx_en, ws, sd, ur;
  logic [1:0]  ur_ch;

  int checks = 0;
  int errors = 0;

  logic        cap_ws [0:255];
  logic        cap_sd [0:255];
  int          ncap;
  logic [31:0] src [0:15];
  int          src_n, src_i;

  always #2 clk = ~clk;

  i2s_tx dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .en_cmd_i(en_cmd), .dis_cmd_i(dis_cmd),
    .fmt_lj_i(fmt_lj), .dlen_i(dlen), .slot24_i(slot24), .mono_i(mono),
    .fill_prev_i(fill_prev), .ur_clr_i(ur_clr), .bit_tick_i(bit_tick),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
    .tx_en_o(tx_en), .ws_o(ws), .sd_o(sd), .ur_o(ur), .ur_ch_o(ur_ch)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input logic [31:0] s, input int dl);
    int          nb;
    logic [31:0] m;
    case (dl)
      0: nb = 32; 1: nb = 24; 2: nb = 20; 3: nb = 18;
      4, 5: nb = 16; default: nb = 8;
    endcase
    m = (nb == 32) ? 32'hFFFF_FFFF : ((32'h1 << nb) - 1);
    return (s & m) << (32 - nb);
  endfunction

  function automatic logic [31:0] slot_at(input int start, input int sw);
    logic [31:0] w = '0;
    for (int b = 0; b < sw; b++) w[31-b] = cap_sd[start+b];
    return w;
  endfunction

  task automatic set_cfg(input logic lj, input logic [2:0] dl, input logic s24,
                         input logic mn, input logic fp);
    fmt_lj = lj; dlen = dl; slot24 = s24; mono = mn; fill_prev = fp;
  endtask

  task automatic restart();
    @(negedge clk) dis_cmd = 1'b1;
    @(negedge clk) begin dis_cmd = 1'b0; en_cmd = 1'b1; end
    @(negedge clk) begin en_cmd = 1'b0; ur_clr = 1'b1; end
    @(negedge clk) ur_clr = 1'b0;
    ncap = 0; src_n = 0; src_i = 0;
  endtask

  task automatic add_src(input logic [31:0] d);
    src[src_n] = d;
    src_n++;
  endtask

  task automatic push(input logic [31:0] d);
    tx_valid = 1'b1; tx_data = d;
    @(negedge clk) tx_valid = 1'b0;
  endtask

  task automatic run_ticks(input int n);
    for (int k = 0; k < n; k++) begin
      if (src_i < src_n && tx_ready) begin
        push(src[src_i]);
        src_i++;
      end
      bit_tick = 1'b1;
      @(negedge clk) bit_tick = 1'b0;
      cap_ws[ncap] = ws;
      cap_sd[ncap] = sd;
      ncap++;
    end
  endtask

  task automatic t_reset();
    check("R1 reset tx_en", 32'(tx_en), 0);
    check("R1 reset ready", 32'(tx_ready), 0);
    check("R1 reset ws/sd", {30'd0, ws, sd}, 0);
    check("R12 reset flags", {29'd0, ur, ur_ch}, 0);
  endtask

  task automatic t_handshake();
    set_cfg(1, 0, 0, 0, 0);
    restart();
    check("R1 enabled", 32'(tx_en), 1);
    check("R2 ready when empty", 32'(tx_ready), 1);
    push(32'h1234_5678);
    check("R2 ready drops after accept", 32'(tx_ready), 0);
    @(negedge clk) begin en_cmd = 1'b1; dis_cmd = 1'b1; end
    @(negedge clk) begin en_cmd = 1'b0; dis_cmd = 1'b0; end
    check("R1 disable wins", 32'(tx_en), 0);
    check("R1 ready low when off", 32'(tx_ready), 0);
    @(negedge clk) en_cmd = 1'b1;
    @(negedge clk) en_cmd = 1'b0;
    check("R2 flushed on disable", 32'(tx_ready), 1);
  endtask

  task automatic t_lj32();
    set_cfg(1, 0, 0, 0, 0);
    restart();
    add_src(32'h8123_4567); add_src(32'hC0DE_F00D);
    add_src(32'h0F0F_1E1E); add_src(32'hFFFF_0001);
    run_ticks(128);
    check("R4 lj f0 left", slot_at(0, 32), 32'h8123_4567);
    check("R4 lj f0 right", slot_at(32, 32), 32'hC0DE_F00D);
    check("R4 lj f1 left", slot_at(64, 32), 32'h0F0F_1E1E);
    check("R4 lj f1 right", slot_at(96, 32), 32'hFFFF_0001);
    check("R3 ws left", {31'd0, cap_ws[0]} | {31'd0, cap_ws[31]}, 0);
    check("R3 ws right", {30'd0, cap_ws[32], cap_ws[63]}, 3);
    check("R3 ws next frame", 32'(cap_ws[64]), 0);
    check("R12 no underrun", 32'(ur_ch), 0);
  endtask

  task automatic t_i2s24();
    set_cfg(0, 1, 1, 0, 0);
    restart();
    add_src(32'h00AB_CDEF); add_src(32'h0080_0001);
    add_src(32'hFF12_3456); add_src(32'h0055_AA55); add_src(32'h0);
    run_ticks(97);
    check("R5 first bit zero", 32'(cap_sd[0]), 0);
    check("R5 i2s f0 left", slot_at(1, 24), exp_word(32'h00AB_CDEF, 1));
    check("R5 i2s f0 right", slot_at(25, 24), exp_word(32'h0080_0001, 1));
    check("R6 i2s f1 left 24b", slot_at(49, 24), exp_word(32'hFF12_3456, 1));
    check("R6 i2s f1 right", slot_at(73, 24), exp_word(32'h0055_AA55, 1));
    check("R7 24-bit slot ws", {30'd0, cap_ws[23], cap_ws[24]}, 1);
    check("R7 24-bit frame", 32'(cap_ws[48]), 0);
  endtask

  task automatic t_slot_sel();
    set_cfg(1, 3, 0, 0, 0);
    restart();
    add_src(32'hFFFE_ABCD); add_src(32'h0001_2345);
    run_ticks(64);
    check("R7 18b slot32 ws", {30'd0, cap_ws[31], cap_ws[32]}, 1);
    check("R6 18b left", slot_at(0, 32), exp_word(32'hFFFE_ABCD, 3));
    check("R6 18b right", slot_at(32, 32), exp_word(32'h0001_2345, 3));
    set_cfg(1, 4, 1, 0, 0);
    restart();
    add_src(32'hDEAD_9ABC); add_src(32'h0000_8001);
    run_ticks(64);
    check("R7 slot24 ignored for 16b", {30'd0, cap_ws[31], cap_ws[32]}, 1);
    check("R6 16b left", slot_at(0, 32), 32'h9ABC_0000);
    check("R6 16b right", slot_at(32, 32), 32'h8001_0000);
  endtask

  task automatic t_packed();
    set_cfg(1, 5, 0, 0, 0);
    restart();
    add_src(32'h8001_7FFE); add_src(32'h1234_ABCD);
    run_ticks(128);
    check("R8 p16 f0 left", slot_at(0, 32), 32'h7FFE_0000);
    check("R8 p16 f0 right", slot_at(32, 32), 32'h8001_0000);
    check("R8 p16 f1 left", slot_at(64, 32), 32'hABCD_0000);
    check("R8 p16 f1 right", slot_at(96, 32), 32'h1234_0000);
    check("R8 p16 one word per frame", 32'(ur_ch), 0);
    set_cfg(1, 7, 0, 0, 0);
    restart();
    add_src(32'h0000_C35A);
    run_ticks(64);
    check("R8 p8 left", slot_at(0, 32), 32'h5A00_0000);
    check("R8 p8 right", slot_at(32, 32), 32'hC300_0000);
    check("R8 p8 no underrun", 32'(ur_ch), 0);
  endtask

  task automatic t_mono();
    set_cfg(1, 4, 0, 1, 0);
    restart();
    add_src(32'h0000_9ABC); add_src(32'h0000_1357);
    run_ticks(128);
    check("R9 mono f0 left", slot_at(0, 32), 32'h9ABC_0000);
    check("R9 mono f0 right", slot_at(32, 32), 32'h9ABC_0000);
    check("R9 mono f1 left", slot_at(64, 32), 32'h1357_0000);
    check("R9 mono f1 right", slot_at(96, 32), 32'h1357_0000);
    check("R9 mono no underrun", 32'(ur_ch), 0);
  endtask

  task automatic t_ur_zero();
    set_cfg(1, 0, 0, 0, 0);
    restart();
    add_src(32'hA5A5_0F0F);
    run_ticks(64);
    check("R10 left sent", slot_at(0, 32), 32'hA5A5_0F0F);
    check("R10 right zero fill", slot_at(32, 32), 32'h0);
    check("R12 right flag only", 32'(ur_ch), 2);
    check("R12 global flag", 32'(ur), 1);
    @(negedge clk) ur_clr = 1'b1;
    @(negedge clk) ur_clr = 1'b0;
    check("R12 flags cleared", {30'd0, ur, ur_ch[0] | ur_ch[1]}, 0);
  endtask

  task automatic t_ur_prev();
    set_cfg(1, 0, 0, 0, 1);
    restart();
    add_src(32'h1111_2222); add_src(32'h3333_4444);
    run_ticks(128);
    check("R11 repeat left", slot_at(64, 32), 32'h1111_2222);
    check("R11 repeat right", slot_at(96, 32), 32'h3333_4444);
    check("R12 both flags", 32'(ur_ch), 3);
  endtask

  task automatic t_cfg_latch();
    set_cfg(1, 0, 0, 0, 0);
    restart();
    add_src(32'hCAFE_BABE); add_src(32'h8765_4321);
    add_src(32'h0000_00A7); add_src(32'h0000_0031);
    run_ticks(10);
    dlen = 3'd6;
    run_ticks(118);
    check("R13 frame kept left", slot_at(0, 32), 32'hCAFE_BABE);
    check("R13 frame kept right", slot_at(32, 32), 32'h8765_4321);
    check("R13 next frame 8b left", slot_at(64, 32), 32'hA700_0000);
    check("R13 next frame 8b right", slot_at(96, 32), 32'h3100_0000);
  endtask

  task automatic t_disable();
    set_cfg(1, 0, 0, 0, 0);
    restart();
    add_src(32'hFFFF_FFFF); add_src(32'hFFFF_FFFF); add_src(32'hFFFF_FFFF);
    run_ticks(40);
    check("R3 in right slot", {30'd0, ws, sd}, 3);
    @(negedge clk) dis_cmd = 1'b1;
    @(negedge clk) dis_cmd = 1'b0;
    @(negedge clk);
    check("R1 disabled quiet", {28'd0, tx_en, tx_ready, ws, sd}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_handshake();
    t_lj32();
    t_i2s24();
    t_slot_sel();
    t_packed();
    t_mono();
    t_ur_zero();
    t_ur_prev();
    t_cfg_latch();
    t_disable();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule